// File: doc/BRIEF.md
# Immediate and Register Shift Operand Unit

This unit turns the shift field of an instruction word into an actual shift of a 32-bit operand. It extracts a 2-bit shift kind and a 5-bit immediate amount from one of two instruction layouts. A wide layout and a compact layout are supported, picked by a select input. The field is then decoded either as an immediate shift or as a register-specified shift. For a register-specified shift, the amount comes from a separate 8-bit input. The selected shift is applied to the operand, and the unit returns the shifted value, a carry-out and an invalid flag.

The unit is purely combinational. An execution stage places it in front of its ALU. The carry-out is meant to feed flag update logic, which lives elsewhere. The special encodings of the immediate form are resolved here: a zero amount means 32 for right shifts, and a zero rotate means a one-bit rotate through carry. Downstream logic therefore only ever sees a shift kind and an explicit amount.

Top module: `bshift_unit`

## Requirements
- R1: With `compact_i`=0 the shift kind is taken from `insn_i[6:5]` and the immediate amount from `insn_i[11:7]`.
- R2: With `compact_i`=1 the shift kind is taken from `insn_i[5:4]`, and the immediate amount is `{insn_i[14:12], insn_i[7:6]}`, with bits 14:12 forming the upper three bits.
- R3: In immediate mode (`reg_mode_i`=0), kind code 0 is a logical left shift by the immediate amount. Codes 1 and 2 are logical right and arithmetic right shifts, for which an immediate amount of 0 is taken as 32.
- R4: In immediate mode, kind code 3 with a nonzero amount is a rotate right by that amount. Code 3 with amount 0 is a one-bit rotate through carry: the result is `{carry_i, operand[31:1]}` and carry-out is operand bit 0.
- R5: In register mode (`reg_mode_i`=1), kind codes 0, 1, 2 and 3 select logical left, logical right, arithmetic right and rotate right. The amount is the full 8-bit `reg_amt_i`, and rotate through carry is never chosen.
- R6: A register-mode shift by 0 returns the operand unchanged, with carry-out equal to `carry_i`.
- R7: A logical left shift by n ≥ 1 yields carry-out equal to operand bit (32−n) for n ≤ 32, and 0 for n > 32. The result is 0 for n ≥ 32.
- R8: A logical right shift by n ≥ 1 yields carry-out equal to operand bit (n−1) for n ≤ 32, and 0 for n > 32. The result is 0 for n ≥ 32.
- R9: An arithmetic right shift by 1 ≤ n ≤ 32 fills vacated bits with operand bit 31, with carry-out equal to operand bit (n−1). For n > 32 the result and carry-out are 0 and `invalid_o` is 1.
- R10: A rotate right by n ≥ 1 rotates by n modulo 32, and carry-out is bit 31 of the rotated result.
- R11: `invalid_o` is 1 only in the case named in R9 and is 0 in every other case. All outputs follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to be shifted |
| carry_i | input | 1 | Incoming carry flag |
| reg_mode_i | input | 1 | 0: immediate-decoded shift, 1: register-specified amount |
| compact_i | input | 1 | 0: wide field layout, 1: compact field layout |
| insn_i | input | 32 | Instruction word holding the shift kind and immediate amount |
| reg_amt_i | input | 8 | Shift amount for register mode |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Shift carry-out |
| invalid_o | output | 1 | Requested shift is not defined |

## Verification
Every result of this unit is due in the same cycle its inputs are applied, because no register lies between any input and any output. The bench changes inputs on the falling clock edge and waits one time unit for the logic to settle. It then samples `result_o`, `carry_o` and `invalid_o` well before the next rising edge, so no sample races a stimulus change. Register-mode amounts reach 40 and beyond, to cover the crossings at 32 and 33 for every shift kind, in both layouts.

// File: rtl/bshift_pkg.sv
// Shared types and field positions for the shift operand unit.
// Assumes a 32-bit instruction word carrying the fields at fixed bit positions.
package bshift_pkg;

    // Decoded shift operation handed from the decoder to the shifter core.
    typedef enum logic [2:0] {
        SHK_LSL = 3'd0,
        SHK_LSR = 3'd1,
        SHK_ASR = 3'd2,
        SHK_ROR = 3'd3,
        SHK_RRX = 3'd4
    } shk_e;

    localparam int IMM_W = 5;

    // Wide layout field positions
    localparam int WIDE_TYP_LO = 5;
    localparam int WIDE_AMT_LO = 7;
    // Compact layout field positions
    localparam int CMP_TYP_LO  = 4;
    localparam int CMP_AHI_LO  = 12;
    localparam int CMP_ALO_LO  = 6;

endpackage

// File: rtl/bshift_fields.sv
// Extracts the 2-bit shift kind and the 5-bit immediate amount from an
// instruction word, in either the wide or the compact layout.
// Assumes INSN_W is large enough to hold bit 14.
module bshift_fields #(
    parameter int INSN_W = 32
) (
    input  logic [INSN_W-1:0]              insn_i,
    input  logic                           compact_i,
    output logic [1:0]                     typ_o,
    output logic [bshift_pkg::IMM_W-1:0]   imm_o
);
    import bshift_pkg::*;

    // Pick field slices according to the layout select.
    always_comb begin
        if (compact_i) begin
            typ_o = insn_i[CMP_TYP_LO +: 2];
            imm_o = {insn_i[CMP_AHI_LO +: 3], insn_i[CMP_ALO_LO +: 2]};
        end else begin
            typ_o = insn_i[WIDE_TYP_LO +: 2];
            imm_o = insn_i[WIDE_AMT_LO +: IMM_W];
        end
    end

endmodule

// File: rtl/bshift_decode.sv
// Turns a shift kind code plus amount into an explicit operation and amount.
// Immediate mode resolves the zero-amount encodings. Register mode maps codes
// straight through and uses the wide register amount.
// Assumes AMT_W can represent DATA_W.
module bshift_decode #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic                          reg_mode_i,
    input  logic [1:0]                    typ_i,
    input  logic [bshift_pkg::IMM_W-1:0]  imm_i,
    input  logic [AMT_W-1:0]              reg_amt_i,
    output bshift_pkg::shk_e              kind_o,
    output logic [AMT_W-1:0]              amt_o
);
    import bshift_pkg::*;

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic             imm_zero;
    logic [AMT_W-1:0] imm_ext;

    assign imm_zero = (imm_i == '0);
    assign imm_ext  = AMT_W'(imm_i);

    // Select operation and effective amount for both modes.
    always_comb begin
        kind_o = SHK_LSL;
        amt_o  = imm_ext;
        if (reg_mode_i) begin
            amt_o = reg_amt_i;
            unique case (typ_i)
                2'd0: kind_o = SHK_LSL;
                2'd1: kind_o = SHK_LSR;
                2'd2: kind_o = SHK_ASR;
                default: kind_o = SHK_ROR;
            endcase
        end else begin
            unique case (typ_i)
                2'd0: kind_o = SHK_LSL;
                2'd1: begin
                    kind_o = SHK_LSR;
                    amt_o  = imm_zero ? FULL_AMT : imm_ext;
                end
                2'd2: begin
                    kind_o = SHK_ASR;
                    amt_o  = imm_zero ? FULL_AMT : imm_ext;
                end
                default: begin
                    kind_o = imm_zero ? SHK_RRX : SHK_ROR;
                    amt_o  = imm_zero ? AMT_W'(1) : imm_ext;
                end
            endcase
        end
    end

endmodule

// File: rtl/bshift_core.sv
// Applies a decoded shift to the operand and produces the result, the carry-out
// and the invalid flag. Each kind is computed on a double-width vector, so
// amounts at and above DATA_W fall out without special cases.
// Assumes DATA_W is a power of two (rotate uses the low amount bits).
module bshift_core #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0]  opnd_i,
    input  logic               carry_i,
    input  bshift_pkg::shk_e   kind_i,
    input  logic [AMT_W-1:0]   amt_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               carry_o,
    output logic               invalid_o
);
    import bshift_pkg::*;

    localparam int RW = $clog2(DATA_W);
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic [2*DATA_W-1:0] lsl_w, lsr_w, asr_w, ror_w;
    logic                amt_zero, amt_over;

    // Double-width shift products, one per kind.
    always_comb begin
        lsl_w = {{DATA_W{1'b0}}, opnd_i} << amt_i;
        lsr_w = {opnd_i, {DATA_W{1'b0}}} >> amt_i;
        asr_w = $unsigned($signed({opnd_i, {DATA_W{1'b0}}}) >>> amt_i);
        ror_w = {opnd_i, opnd_i} >> amt_i[RW-1:0];
    end

    assign amt_zero = (amt_i == '0);
    assign amt_over = (amt_i > FULL_AMT);

    // Choose the output triple by kind, with zero-amount and invalid handling.
    always_comb begin
        result_o  = '0;
        carry_o   = 1'b0;
        invalid_o = 1'b0;
        if (kind_i == SHK_RRX && amt_i != AMT_W'(1)) begin
            invalid_o = 1'b1;
        end else if (amt_zero) begin
            result_o = opnd_i;
            carry_o  = carry_i;
        end else begin
            unique case (kind_i)
                SHK_LSL: begin
                    result_o = lsl_w[DATA_W-1:0];
                    carry_o  = lsl_w[DATA_W];
                end
                SHK_LSR: begin
                    result_o = lsr_w[2*DATA_W-1:DATA_W];
                    carry_o  = lsr_w[DATA_W-1];
                end
                SHK_ASR: begin
                    if (amt_over) begin
                        invalid_o = 1'b1;
                    end else begin
                        result_o = asr_w[2*DATA_W-1:DATA_W];
                        carry_o  = asr_w[DATA_W-1];
                    end
                end
                SHK_ROR: begin
                    result_o = ror_w[DATA_W-1:0];
                    carry_o  = ror_w[DATA_W-1];
                end
                default: begin
                    result_o = {carry_i, opnd_i[DATA_W-1:1]};
                    carry_o  = opnd_i[0];
                end
            endcase
        end
    end

endmodule

// File: rtl/bshift_unit.sv
// Top level of the shift operand unit: field extraction, decode and shifter
// core in series. Purely combinational, so it has no clock and no reset.
// Assumes the instruction word is 32 bits wide.
module bshift_unit #(
    parameter int DATA_W = 32,
    parameter int INSN_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              carry_i,
    input  logic              reg_mode_i,
    input  logic              compact_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [AMT_W-1:0]  reg_amt_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              invalid_o
);
    import bshift_pkg::*;

    logic [1:0]       typ_w;
    logic [IMM_W-1:0] imm_w;
    shk_e             kind_w;
    logic [AMT_W-1:0] amt_w;

    bshift_fields #(.INSN_W(INSN_W)) u_fields (
        .insn_i    (insn_i),
        .compact_i (compact_i),
        .typ_o     (typ_w),
        .imm_o     (imm_w)
    );

    bshift_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_decode (
        .reg_mode_i (reg_mode_i),
        .typ_i      (typ_w),
        .imm_i      (imm_w),
        .reg_amt_i  (reg_amt_i),
        .kind_o     (kind_w),
        .amt_o      (amt_w)
    );

    bshift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .opnd_i    (opnd_i),
        .carry_i   (carry_i),
        .kind_i    (kind_w),
        .amt_i     (amt_w),
        .result_o  (result_o),
        .carry_o   (carry_o),
        .invalid_o (invalid_o)
    );

endmodule

// File: rtl/bshift_unit_chk.sv
// Checker for the shift operand unit, bound to every instance of it.
// It relates the decoder's outputs to the unit's ports. Assertions are
// immediate, since the unit has no clock.
module bshift_unit_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input logic [DATA_W-1:0] opnd_i,
    input logic              carry_i,
    input logic              reg_mode_i,
    input logic [AMT_W-1:0]  reg_amt_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o,
    input logic              invalid_o,
    input bshift_pkg::shk_e  kind_w,
    input logic [AMT_W-1:0]  amt_w
);
    import bshift_pkg::*;

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    // Check the port-level invariants whenever any input changes.
    always_comb begin
        // R11
        invalid_src_chk: assert (!invalid_o || (reg_mode_i && kind_w == SHK_ASR && amt_w > FULL_AMT))
            else $error("invalid raised outside register ASR above width");
        // R9
        invalid_zero_chk: assert (!invalid_o || (result_o == '0 && !carry_o))
            else $error("invalid shift produced nonzero outputs");
        // R5
        reg_no_rrx_chk: assert (!(reg_mode_i && kind_w == SHK_RRX))
            else $error("register mode selected rotate through carry");
        // R4
        rrx_amt_one_chk: assert (kind_w != SHK_RRX || amt_w == AMT_W'(1))
            else $error("rotate through carry with amount other than one");
        // R6
        zero_pass_chk: assert (!(reg_mode_i && reg_amt_i == '0) || (result_o == opnd_i && carry_o == carry_i))
            else $error("zero register shift did not pass operand through");
        // R7
        far_left_chk: assert (!(kind_w == SHK_LSL && amt_w >= FULL_AMT) || result_o == '0)
            else $error("left shift at or beyond width left bits set");
        // R8
        far_right_chk: assert (!(kind_w == SHK_LSR && amt_w >= FULL_AMT) || result_o == '0)
            else $error("right shift at or beyond width left bits set");
    end

endmodule

bind bshift_unit bshift_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .opnd_i     (opnd_i),
    .carry_i    (carry_i),
    .reg_mode_i (reg_mode_i),
    .reg_amt_i  (reg_amt_i),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .invalid_o  (invalid_o),
    .kind_w     (kind_w),
    .amt_w      (amt_w)
);

// File: tb/bshift_unit_bench.sv
// Self-checking bench for the shift operand unit. A fixed-seed random sweep and
// directed corners are compared against reference functions written from the
// requirements.
module bshift_unit_bench;

    logic        clk = 1'b0;
    logic [31:0] opnd_i;
    logic        carry_i;
    logic        reg_mode_i;
    logic        compact_i;
    logic [31:0] insn_i;
    logic [7:0]  reg_amt_i;
    logic [31:0] result_o;
    logic        carry_o;
    logic        invalid_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // 250 MHz clock: 4 time units per period (1 ns units).
    always #2 clk = ~clk;

    bshift_unit u_bshift_unit (
        .opnd_i     (opnd_i),
        .carry_i    (carry_i),
        .reg_mode_i (reg_mode_i),
        .compact_i  (compact_i),
        .insn_i     (insn_i),
        .reg_amt_i  (reg_amt_i),
        .result_o   (result_o),
        .carry_o    (carry_o),
        .invalid_o  (invalid_o)
    );

    // Place kind code and 5-bit amount into a word, per R1 / R2.
    function automatic logic [31:0] make_insn(input logic cmp, input int typ, input int amt, input logic [31:0] fill);
        logic [31:0] w = fill;
        if (cmp) begin
            w[5:4]   = typ[1:0];
            w[14:12] = amt[4:2];
            w[7:6]   = amt[1:0];
        end else begin
            w[6:5]   = typ[1:0];
            w[11:7]  = amt[4:0];
        end
        return w;
    endfunction

    // Reference shift. kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX.
    function automatic void ref_shift(input logic [31:0] v, input int kind, input int n, input logic cin,
                                      output logic [31:0] r, output logic c, output logic inv);
        r = '0; c = 1'b0; inv = 1'b0;
        if (n == 0 && kind != 4) begin
            r = v; c = cin;
            return;
        end
        case (kind)
            0: begin
                for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? v[i - n] : 1'b0;
                c = (n <= 32) ? v[32 - n] : 1'b0;
            end
            1: begin
                for (int i = 0; i < 32; i++) r[i] = (i + n <= 31) ? v[i + n] : 1'b0;
                c = (n <= 32) ? v[n - 1] : 1'b0;
            end
            2: begin
                if (n > 32) inv = 1'b1;
                else begin
                    for (int i = 0; i < 32; i++) r[i] = (i + n <= 31) ? v[i + n] : v[31];
                    c = v[n - 1];
                end
            end
            3: begin
                for (int i = 0; i < 32; i++) r[i] = v[(i + n % 32) % 32];
                c = r[31];
            end
            default: begin
                r = {cin, v[31:1]};
                c = v[0];
            end
        endcase
    endfunction

    // Drive one vector away from the rising edge, settle, compare.
    task automatic apply(input logic [31:0] v, input logic cin, input logic rm, input logic cmp,
                         input int typ, input int imm, input int ramt);
        int kind, n;
        logic [31:0] er; logic ec, ei;
        string tag;
        @(negedge clk);
        opnd_i = v; carry_i = cin; reg_mode_i = rm; compact_i = cmp;
        insn_i = make_insn(cmp, typ, imm, $urandom); reg_amt_i = ramt[7:0];
        if (rm) begin
            kind = typ; n = ramt;
        end else if (typ == 0) begin
            kind = 0; n = imm;
        end else if (typ == 3) begin
            kind = (imm == 0) ? 4 : 3; n = (imm == 0) ? 1 : imm;
        end else begin
            kind = typ; n = (imm == 0) ? 32 : imm;
        end
        ref_shift(v, kind, n, cin, er, ec, ei);
        tag = cmp ? "R2" : "R1";
        tag = {tag, rm ? "/R5" : "/R3"};
        if (rm && n == 0) tag = {tag, "/R6"};
        else case (kind)
            0: tag = {tag, "/R7"};
            1: tag = {tag, "/R8"};
            2: tag = {tag, ei ? "/R9/R11" : "/R9"};
            3: tag = {tag, "/R10"};
            default: tag = {tag, "/R4"};
        endcase
        #1;
        n_vec++;
        if (result_o !== er || carry_o !== ec || invalid_o !== ei) begin
            n_fail++;
            $display("FAIL %s kind=%0d n=%0d opnd=%h cin=%0b: got res=%h c=%0b inv=%0b exp res=%h c=%0b inv=%0b",
                     tag, kind, n, v, cin, result_o, carry_o, invalid_o, er, ec, ei);
        end
    endtask

    // Watchdog: a hung run counts as a miscompare and still reports.
    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    // Stimulus: reset-like all-zero state, directed corners, then random sweep.
    initial begin
        void'($urandom(32'd1234));
        opnd_i = '0; carry_i = 0; reg_mode_i = 0; compact_i = 0; insn_i = '0; reg_amt_i = '0;
        // R11: all-zero inputs give zero outputs and no invalid flag
        #1;
        n_vec++;
        if (result_o !== 32'h0 || carry_o !== 1'b0 || invalid_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 idle: got %h/%0b/%0b exp 0/0/0", result_o, carry_o, invalid_o);
        end
        // Directed corners around 0, 1, 31, 32, 33 and the top amount
        apply(32'h8000_0001, 1'b1, 1'b0, 1'b0, 3, 0, 0);      // R4 rrx
        apply(32'h0000_0002, 1'b0, 1'b0, 1'b1, 3, 0, 0);      // R4 rrx, compact
        apply(32'h8000_0000, 1'b0, 1'b0, 1'b0, 2, 0, 0);      // R3 asr by 32
        apply(32'h0000_0001, 1'b1, 1'b1, 1'b0, 0, 0, 32);     // R7 lsl 32
        apply(32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 0, 0, 33);     // R7 lsl 33
        apply(32'h8000_0000, 1'b0, 1'b1, 1'b0, 1, 0, 32);     // R8 lsr 32
        apply(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1, 0, 255);    // R8 lsr 255
        apply(32'h8000_0000, 1'b1, 1'b1, 1'b0, 2, 0, 33);     // R9 invalid
        apply(32'h7FFF_FFFF, 1'b1, 1'b1, 1'b1, 2, 0, 32);     // R9 asr 32 positive
        apply(32'h0000_0001, 1'b0, 1'b1, 1'b0, 3, 0, 32);     // R10 ror 32
        apply(32'h0000_0003, 1'b0, 1'b1, 1'b1, 3, 0, 33);     // R10 ror 33
        apply(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 2, 0, 0);      // R6
        apply(32'hDEAD_BEEF, 1'b0, 1'b1, 1'b1, 3, 0, 0);      // R6
        // Sweep all layouts, modes, kinds and amounts
        for (int cmp = 0; cmp < 2; cmp++)
            for (int typ = 0; typ < 4; typ++) begin
                for (int a = 0; a < 32; a++)
                    for (int k = 0; k < 2; k++)
                        apply($urandom, 1'($urandom), 1'b0, 1'(cmp), typ, a, 0);
                for (int a = 0; a <= 40; a++)
                    for (int k = 0; k < 2; k++)
                        apply($urandom, 1'($urandom), 1'b1, 1'(cmp), typ, 0, a);
                for (int k = 0; k < 8; k++)
                    apply($urandom, 1'($urandom), 1'b1, 1'(cmp), typ, 0, int'($urandom_range(41, 255)));
            end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule